// File: doc/BRIEF.md
# Snooping Byte-Lane Parity Checker

This block sits on a tap of the bus between a host and its SDRAM. It only watches: every pin it touches is an input, so the host-to-memory data path is never driven or delayed. When it sees a write, it works out one even-parity bit for each byte lane of the data. Those bits go into a narrow side memory, one bit per lane, held at the same address as the data word. Lanes whose byte enable is low keep the bits they already had.

When it sees a read command, the block snapshots the stored check bits for that address. It then waits the configured CAS latency and samples the returned data. It recomputes the lane parities and compares them with the snapshot. A lane that has never been written since reset is excluded from the comparison.

The first mismatch raises a sticky interrupt and latches the failing address and the lanes that failed. These stay until the host pulses the write-one-to-clear input. The block only detects errors; it never corrects data.

Top module: `snoop_parity_chk`

## Requirements
- R1: After reset, `irq` is 0, `err_addr` is 0 and `err_lanes` is 0.
- R2: A cycle with `bus_cmd_vld`=1 and `bus_wr`=1 stores, for each lane l with `bus_be[l]`=1, the XOR of `bus_wdata[8l+7:8l]` as the check bit of lane l at `bus_addr`. Lanes with `bus_be[l]`=0 keep their earlier check bit.
- R3: For a read command (`bus_cmd_vld`=1, `bus_wr`=0) accepted at clock edge k, `bus_rdata` is sampled at edge k+CAS_LAT and at no other edge. Lane l mismatches when the XOR of `bus_rdata[8l+7:8l]` differs from the stored check bit of lane l.
- R4: A lane never written since reset never reports a mismatch, whatever data is returned.
- R5: On a mismatch while `irq` is 0, `irq` becomes 1 right after the sampling edge. `err_addr` takes the read address, and `err_lanes` takes the mismatch mask, in which bit l stands for lane l.
- R6: While `irq` is 1 and `irq_clr` is 0, `irq`, `err_addr` and `err_lanes` hold, and later mismatches are ignored.
- R7: `irq_clr`=1 at an edge clears `irq`, `err_addr` and `err_lanes` to 0. If a mismatch is sampled at that same edge, the new error is captured instead.
- R8: The check for a read uses the check bits held when the read command was accepted. A write to the same address issued while that read is still pending does not affect it.
- R9: Cycles with `bus_cmd_vld`=0 change no stored bit and no output, whatever `bus_wdata` and `bus_rdata` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cmd_vld | input | 1 | A command is on the bus this cycle |
| bus_wr | input | 1 | 1 = write command, 0 = read command |
| bus_addr | input | AW | Word address of the command |
| bus_be | input | DW/8 | Byte enables of a write |
| bus_wdata | input | DW | Write data seen on the bus |
| bus_rdata | input | DW | Read data returned by the memory |
| irq_clr | input | 1 | Write-one-to-clear strobe for the error state |
| irq | output | 1 | Sticky parity-error interrupt |
| err_addr | output | AW | Address of the first failing read |
| err_lanes | output | DW/8 | Failing lanes of that read |

## Verification
A read accepted at edge k is judged from the data present at edge k+CAS_LAT. Its effect on `irq` and the error fields is visible from just after that edge. A write changes the check bits at the edge that accepts it, and a clear acts at its own edge.

The bench drives inputs on falling edges. It runs a behavioural model on rising edges, which keeps pending reads in a queue tagged with their due cycle, and compares all outputs on every falling edge. On cycles that are not due for sampling, `bus_rdata` carries random data, so sampling at any other cycle would raise a spurious error.

// File: rtl/snoop_parity_chk.sv
module snoop_parity_chk #(
  parameter int AW      = 8,
  parameter int DW      = 32,
  parameter int CAS_LAT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_cmd_vld,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW/8-1:0] bus_be,
  input  logic [DW-1:0]   bus_wdata,
  input  logic [DW-1:0]   bus_rdata,
  input  logic            irq_clr,
  output logic            irq,
  output logic [AW-1:0]   err_addr,
  output logic [DW/8-1:0] err_lanes
);
  localparam int LANES = DW / 8;
  localparam int DEPTH = 1 << AW;
  localparam int LAST  = CAS_LAT - 1;

  logic [LANES-1:0] wpar, rpar, mism;
  logic [LANES-1:0] par_mem [DEPTH];
  logic [LANES-1:0] vld_mem [DEPTH];

  logic [CAS_LAT-1:0] pv;
  logic [AW-1:0]      pa [CAS_LAT];
  logic [LANES-1:0]   pp [CAS_LAT];
  logic [LANES-1:0]   pm [CAS_LAT];

  wire wr_hit = bus_cmd_vld & bus_wr;
  wire rd_hit = bus_cmd_vld & ~bus_wr;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign wpar[l] = ^bus_wdata[8*l +: 8];
    assign rpar[l] = ^bus_rdata[8*l +: 8];
  end

  always_ff @(posedge clk)
    if (wr_hit)
      par_mem[bus_addr] <= (par_mem[bus_addr] & ~bus_be) | (wpar & bus_be);

  always_ff @(posedge clk)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) vld_mem[i] <= '0;
    end else if (wr_hit) begin
      vld_mem[bus_addr] <= vld_mem[bus_addr] | bus_be;
    end

  always_ff @(posedge clk) begin
    if (!rst_n) pv[0] <= 1'b0;
    else        pv[0] <= rd_hit;
    pa[0] <= bus_addr;
    pp[0] <= par_mem[bus_addr];
    pm[0] <= vld_mem[bus_addr];
  end

  for (genvar s = 1; s < CAS_LAT; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) pv[s] <= 1'b0;
      else        pv[s] <= pv[s-1];
      pa[s] <= pa[s-1];
      pp[s] <= pp[s-1];
      pm[s] <= pm[s-1];
    end
  end

  assign mism = pv[LAST] ? ((rpar ^ pp[LAST]) & pm[LAST]) : '0;

  always_ff @(posedge clk)
    if (!rst_n) begin
      irq       <= 1'b0;
      err_addr  <= '0;
      err_lanes <= '0;
    end else if (|mism && (!irq || irq_clr)) begin
      irq       <= 1'b1;
      err_addr  <= pa[LAST];
      err_lanes <= mism;
    end else if (irq_clr) begin
      irq       <= 1'b0;
      err_addr  <= '0;
      err_lanes <= '0;
    end
endmodule

// File: rtl/snoop_parity_chk_sva.sv
module snoop_parity_chk_sva #(
  parameter int AW    = 8,
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_clr,
  input logic             irq,
  input logic [AW-1:0]    err_addr,
  input logic [LANES-1:0] err_lanes
);
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);

  p_hold_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> $stable(err_addr) && $stable(err_lanes));

  p_lanes_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> err_lanes != '0);

  p_idle_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> err_lanes == '0 && err_addr == '0);
endmodule

bind snoop_parity_chk snoop_parity_chk_sva #(.AW(AW), .LANES(DW/8)) u_sva (
  .clk(clk), .rst_n(rst_n), .irq_clr(irq_clr), .irq(irq),
  .err_addr(err_addr), .err_lanes(err_lanes)
);

// File: tb/snoop_parity_chk_tb.sv
`timescale 1ns/1ps
module snoop_parity_chk_tb;
  localparam int AW = 8, DW = 32, CAS = 2, LN = DW / 8;

  logic clk = 0, rst_n = 0;
  logic cv = 0, wr = 0, clr = 0;
  logic [AW-1:0] addr = '0;
  logic [LN-1:0] be = '0;
  logic [DW-1:0] wd = '0, rd = '0;
  logic irq;
  logic [AW-1:0] e_a_o;
  logic [LN-1:0] e_l_o;

  always #2.5 clk = ~clk;

  snoop_parity_chk #(.AW(AW), .DW(DW), .CAS_LAT(CAS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_cmd_vld(cv), .bus_wr(wr), .bus_addr(addr),
    .bus_be(be), .bus_wdata(wd), .bus_rdata(rd), .irq_clr(clr),
    .irq(irq), .err_addr(e_a_o), .err_lanes(e_l_o));

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  string req = "R1";

  bit [LN-1:0] m_par [256];
  bit [LN-1:0] m_vld [256];
  bit [DW-1:0] dmem  [256];
  int          q_due  [$];
  bit [AW-1:0] q_addr [$];
  bit [LN-1:0] q_par  [$];
  bit [LN-1:0] q_vld  [$];
  bit          x_irq;
  bit [AW-1:0] x_addr;
  bit [LN-1:0] x_lanes;

  function automatic bit [LN-1:0] lanep(bit [DW-1:0] d);
    bit [LN-1:0] r;
    for (int l = 0; l < LN; l++) begin
      r[l] = 0;
      for (int b = 0; b < 8; b++) r[l] ^= d[8*l+b];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    bit [LN-1:0] mm;
    bit [AW-1:0] ma;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) m_vld[i] = 0;
      q_due.delete(); q_addr.delete(); q_par.delete(); q_vld.delete();
      x_irq = 0; x_addr = 0; x_lanes = 0; cyc = 0;
    end else begin
      cyc++;
      mm = 0; ma = 0;
      if (q_due.size() > 0 && q_due[0] == cyc) begin
        mm = (lanep(rd) ^ q_par[0]) & q_vld[0];
        ma = q_addr[0];
        void'(q_due.pop_front()); void'(q_addr.pop_front());
        void'(q_par.pop_front()); void'(q_vld.pop_front());
      end
      if (mm != 0 && (!x_irq || clr)) begin
        x_irq = 1; x_addr = ma; x_lanes = mm;
      end else if (clr) begin
        x_irq = 0; x_addr = 0; x_lanes = 0;
      end
      if (cv && wr) begin
        m_par[addr] = (m_par[addr] & ~be) | (lanep(wd) & be);
        m_vld[addr] = m_vld[addr] | be;
      end
      if (cv && !wr) begin
        q_due.push_back(cyc + CAS); q_addr.push_back(addr);
        q_par.push_back(m_par[addr]); q_vld.push_back(m_vld[addr]);
      end
    end
  end

  task automatic compare();
    checks++;
    if (irq !== x_irq || e_a_o !== x_addr || e_l_o !== x_lanes) begin
      errors++;
      $display("FAIL %s: irq/addr/lanes = %0b/%0h/%0h expected %0b/%0h/%0h",
               req, irq, e_a_o, e_l_o, x_irq, x_addr, x_lanes);
    end
  endtask

  task automatic tick(bit v, bit w, bit [AW-1:0] a, bit [LN-1:0] b,
                      bit [DW-1:0] d, bit [DW-1:0] r, bit c);
    cv = v; wr = w; addr = a; be = b; wd = d; rd = r; clr = c;
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(0, 0, $urandom, $urandom, $urandom, $urandom, 0);
  endtask

  task automatic write(bit [AW-1:0] a, bit [LN-1:0] b, bit [DW-1:0] d);
    for (int l = 0; l < LN; l++) if (b[l]) dmem[a][8*l +: 8] = d[8*l +: 8];
    tick(1, 1, a, b, d, $urandom, 0);
  endtask

  task automatic read(bit [AW-1:0] a, bit [DW-1:0] flip, bit c_at_data);
    tick(1, 0, a, $urandom, $urandom, $urandom, 0);
    idle(CAS - 1);
    tick(0, 0, $urandom, $urandom, $urandom, dmem[a] ^ flip, c_at_data);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    req = "R1"; compare();

    req = "R2"; write(8'h05, 4'hF, 32'hA5C3_1E07); read(8'h05, 0, 0); idle(1);
    req = "R4"; dmem[8'h09] = 32'hDEAD_BEEF; read(8'h09, 32'h0101_0101, 0); idle(1);
    req = "R2"; write(8'h05, 4'h1, 32'h0000_0001); read(8'h05, 0, 0); idle(1);
    req = "R9"; idle(6); read(8'h05, 0, 0);
    req = "R5"; read(8'h05, 32'h0004_0000, 0); idle(2);
    req = "R6"; write(8'h07, 4'hF, 32'h1234_5678); read(8'h07, 32'h0000_0100, 0); idle(3);
    req = "R7"; tick(0, 0, 0, 0, 0, $urandom, 1); idle(2);
    req = "R4"; write(8'h14, 4'h3, 32'h0000_BEEF); read(8'h14, 32'h0101_0000, 0); idle(1);
    req = "R8";
    write(8'h1E, 4'hF, 32'h0F0F_0F0F);
    tick(1, 0, 8'h1E, 0, 0, $urandom, 0);
    tick(1, 1, 8'h1E, 4'hF, 32'h0F0F_0F0E, $urandom, 0);
    tick(0, 0, 0, 0, 0, 32'h0F0F_0F0F, 0);
    dmem[8'h1E] = 32'h0F0F_0F0E;
    read(8'h1E, 0, 0); idle(1);
    req = "R3"; read(8'h28, 0, 0); write(8'h28, 4'hF, 32'h7777_0001); read(8'h28, 32'h0000_0010, 0); idle(1);
    req = "R7"; write(8'h29, 4'hF, 32'h0055_AA01); read(8'h29, 32'h8000_0001, 1); idle(2);
    tick(0, 0, 0, 0, 0, 0, 1); idle(1);
    req = "R5"; write(8'hFF, 4'hF, 32'hFFFF_FFFF); read(8'hFF, 32'h0000_0100, 0); idle(1);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule